// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers a parameterised set of peripheral interrupt lines (64 by default), grouped into 32-bit banks, and reduces them to two processor request outputs. One is a normal interrupt request and the other is a fast interrupt request. Each line has its own settings. It can be level or edge sensitive. It can be active-high or rising, or active-low or falling. It can be steered to either output. It also has an enable bit. Software programs these settings through a simple word-addressed register bus with a single-cycle write strobe and a combinational read port.

Software changes enables either by writing whole words directly or by writing atomic set and clear masks. It acknowledges latched edges by writing ones. It can raise any line from a software-interrupt register. It can read raw, IRQ-qualified and FIQ-qualified status, and it can fetch the number of the lowest pending IRQ line. A two-bit master enable gates the two outputs independently. External lines are synchronised with two flops before sensing. An asynchronous reset is released through a local synchroniser.

Top module: `intc_dual_route`

## Requirements
- R1: The word address is {group[3:0], bank[1:0]}. Line n lives in bank n/32 at bit n mod 32. Group codes: 0 route, 1 enable, 2 enable-set, 3 enable-clear, 4 type, 5 polarity, 6 software, 7 acknowledge, 8 raw, 9 IRQ status, 10 FIQ status, 11 master (bank 0), 12 pending number (bank 0).
- R2: After reset, every configuration register and the master enable are 0, both outputs are low, and the pending number reads 0xFFFF_FFFF.
- R3: A level line (type bit 0) shows in raw status as its synchronised input XOR its polarity bit (1 means active-low). The delay is two clocks.
- R4: An edge line (type bit 1) latches a rising edge when its polarity bit is 0 and a falling edge when it is 1. The latch stays set after the input returns to idle, and the opposite edge sets nothing.
- R5: Writing 1s to the acknowledge group clears those edge latches. A new edge that arrives in the same cycle as the acknowledge wins, and the latch stays set.
- R6: Enable-set ORs its data into the enable register and enable-clear removes its 1 bits. Zero bits change nothing. The enable group can also be written whole.
- R7: A route bit of 1 steers the line to FIQ and 0 steers it to IRQ. IRQ status is raw & enable & ~route, and FIQ status is raw & enable & route.
- R8: Master bit 0 gates the IRQ output and bit 1 gates the FIQ output. Each output is high when its bit is set and any of its status bits are set.
- R9: The software register ORs its bits into raw status in the cycle after the write.
- R10: The pending number is the lowest line number with IRQ status set, or 0xFFFF_FFFF if there is none.
- R11: Write-only groups (2, 3, 7), banks beyond the configured count, and master or pending at bank 1 or higher all read 0, and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Peripheral interrupt inputs |
| bus_we | input | 1 | Register write strobe, one cycle per word |
| bus_addr | input | BANK_AW+4 | Word address {group, bank} |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Combinational read data for bus_addr |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The case hardest to reach from the ports is a fresh edge and an acknowledge of the same line landing in one clock. The edge appears only after the input has crossed the two-flop synchroniser and the previous-value flop. The stimulus raises the input on a falling clock edge and waits for exactly two rising edges. It then places the acknowledge write so that it is captured on the third rising edge, which is the edge on which the detected edge enters the latch. Configuration and status decoding are covered by a table of write and read pairs that uses software interrupts, so that those checks do not depend on synchroniser timing.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [3:0] {
    GRP_ROUTE  = 4'd0,
    GRP_EN     = 4'd1,
    GRP_EN_SET = 4'd2,
    GRP_EN_CLR = 4'd3,
    GRP_TYPE   = 4'd4,
    GRP_POL    = 4'd5,
    GRP_SOFT   = 4'd6,
    GRP_ACK    = 4'd7,
    GRP_RAW    = 4'd8,
    GRP_IRQ_ST = 4'd9,
    GRP_FIQ_ST = 4'd10,
    GRP_MASTER = 4'd11,
    GRP_PEND   = 4'd12
  } grp_e;

  localparam logic [31:0] NO_PEND = 32'hFFFF_FFFF;

endpackage

// File: rtl/intc_line_sense.sv
module intc_line_sense #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_in,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] act_low,
  input  logic [W-1:0] ack,
  output logic [W-1:0] sensed
);

  logic [W-1:0] sync1_q, sync2_q, prev_q, latch_q;
  logic [W-1:0] rise, fall, edge_now, latch_d;

  always_comb begin
    rise     = sync2_q & ~prev_q;
    fall     = ~sync2_q & prev_q;
    edge_now = edge_mode & ((act_low & fall) | (~act_low & rise));
    latch_d  = (latch_q & ~ack) | edge_now;
    sensed   = (edge_mode & latch_q) | (~edge_mode & (sync2_q ^ act_low));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      latch_q <= latch_d;
    end
  end

  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_now & ack)) |=> ((latch_q & $past(edge_now & ack)) == $past(edge_now & ack))); // R5

  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~edge_now)) |=> ((latch_q & $past(ack & ~edge_now)) == '0)); // R5

endmodule

// File: rtl/intc_bank_regs.sv
module intc_bank_regs
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  grp_e         grp,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] route_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] soft_q,
  output logic [W-1:0] ack
);

  logic [W-1:0] route_d, en_d, type_d, pol_d, soft_d;

  always_comb begin
    route_d = route_q;
    en_d    = en_q;
    type_d  = type_q;
    pol_d   = pol_q;
    soft_d  = soft_q;
    ack     = '0;
    if (wr) begin
      case (grp)
        GRP_ROUTE:  route_d = wdata;
        GRP_EN:     en_d    = wdata;
        GRP_EN_SET: en_d    = en_q | wdata;
        GRP_EN_CLR: en_d    = en_q & ~wdata;
        GRP_TYPE:   type_d  = wdata;
        GRP_POL:    pol_d   = wdata;
        GRP_SOFT:   soft_d  = wdata;
        GRP_ACK:    ack     = wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
      type_q  <= '0;
      pol_q   <= '0;
      soft_q  <= '0;
    end else begin
      route_q <= route_d;
      en_q    <= en_d;
      type_q  <= type_d;
      pol_q   <= pol_d;
      soft_q  <= soft_d;
    end
  end

  AST_EN_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp == GRP_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata))); // R6

  AST_EN_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp == GRP_EN_CLR) |=> ((en_q & $past(wdata)) == '0)); // R6

  AST_EN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp == GRP_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q))); // R6

endmodule

// File: rtl/intc_lowest_pend.sv
module intc_lowest_pend #(
  parameter int N     = 64,
  parameter int OUT_W = 32
) (
  input  logic [N-1:0]     req,
  output logic [OUT_W-1:0] num
);

  always_comb begin
    num = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) num = OUT_W'(i);
    end
  end

endmodule

// File: rtl/intc_dual_route.sv
module intc_dual_route
  import intc_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int BANK_W    = 32,
  parameter int BANK_AW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_we,
  input  logic [BANK_AW+3:0]   bus_addr,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic                 irq_out,
  output logic                 fiq_out
);

  localparam int NUM_BANKS = NUM_LINES / BANK_W;
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  grp_e               grp;
  logic [BANK_AW-1:0] bank_sel;
  logic [BIDX_W-1:0]  bank_idx;
  logic               bank_ok;

  assign grp      = grp_e'(bus_addr[BANK_AW+3:BANK_AW]);
  assign bank_sel = bus_addr[BANK_AW-1:0];
  assign bank_idx = bank_sel[BIDX_W-1:0];
  assign bank_ok  = (32'(bank_sel) < NUM_BANKS);

  logic [BANK_W-1:0] route_b [NUM_BANKS];
  logic [BANK_W-1:0] en_b    [NUM_BANKS];
  logic [BANK_W-1:0] type_b  [NUM_BANKS];
  logic [BANK_W-1:0] pol_b   [NUM_BANKS];
  logic [BANK_W-1:0] soft_b  [NUM_BANKS];
  logic [BANK_W-1:0] raw_b   [NUM_BANKS];
  logic [BANK_W-1:0] irq_b   [NUM_BANKS];
  logic [BANK_W-1:0] fiq_b   [NUM_BANKS];
  logic [NUM_LINES-1:0] irq_flat, fiq_flat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              bank_wr;
    logic [BANK_W-1:0] ack_w, sensed_w;

    assign bank_wr = bus_we && (bank_sel == BANK_AW'(b));

    intc_bank_regs #(.W(BANK_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr      (bank_wr),
      .grp     (grp),
      .wdata   (bus_wdata),
      .route_q (route_b[b]),
      .en_q    (en_b[b]),
      .type_q  (type_b[b]),
      .pol_q   (pol_b[b]),
      .soft_q  (soft_b[b]),
      .ack     (ack_w)
    );

    intc_line_sense #(.W(BANK_W)) u_sense (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .line_in   (irq_lines[b*BANK_W +: BANK_W]),
      .edge_mode (type_b[b]),
      .act_low   (pol_b[b]),
      .ack       (ack_w),
      .sensed    (sensed_w)
    );

    assign raw_b[b] = sensed_w | soft_b[b];
    assign irq_b[b] = raw_b[b] & en_b[b] & ~route_b[b];
    assign fiq_b[b] = raw_b[b] & en_b[b] & route_b[b];
    assign irq_flat[b*BANK_W +: BANK_W] = irq_b[b];
    assign fiq_flat[b*BANK_W +: BANK_W] = fiq_b[b];
  end

  logic [1:0] master_q, master_d;

  always_comb begin
    master_d = master_q;
    if (bus_we && grp == GRP_MASTER && bank_sel == '0) master_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) master_q <= 2'b00;
    else             master_q <= master_d;
  end

  logic [BANK_W-1:0] pend_num;

  intc_lowest_pend #(.N(NUM_LINES), .OUT_W(BANK_W)) u_pend (
    .req (irq_flat),
    .num (pend_num)
  );

  assign irq_out = master_q[0] & (|irq_flat);
  assign fiq_out = master_q[1] & (|fiq_flat);

  always_comb begin
    bus_rdata = '0;
    if (bank_ok) begin
      case (grp)
        GRP_ROUTE:  bus_rdata = route_b[bank_idx];
        GRP_EN:     bus_rdata = en_b[bank_idx];
        GRP_TYPE:   bus_rdata = type_b[bank_idx];
        GRP_POL:    bus_rdata = pol_b[bank_idx];
        GRP_SOFT:   bus_rdata = soft_b[bank_idx];
        GRP_RAW:    bus_rdata = raw_b[bank_idx];
        GRP_IRQ_ST: bus_rdata = irq_b[bank_idx];
        GRP_FIQ_ST: bus_rdata = fiq_b[bank_idx];
        GRP_MASTER: bus_rdata = (bank_sel == '0) ? BANK_W'(master_q) : '0;
        GRP_PEND:   bus_rdata = (bank_sel == '0) ? pend_num : '0;
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_PEND_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_q[0] && pend_num != NO_PEND) |-> irq_out); // R10

  AST_PEND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_num != NO_PEND) |-> (pend_num < BANK_W'(NUM_LINES))); // R10

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> (pend_num != NO_PEND)); // R8

endmodule

// File: tb/sim_intc_dual_route.sv
`timescale 1ns/100ps
module sim_intc_dual_route;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq_lines;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  always #2.5 clk = ~clk;

  intc_dual_route u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out)
  );

  typedef struct packed {
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // address = group*4 + bank; 63 is an unused slot used as a harmless write
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{6'd24, 32'h30,         6'd32, 32'h30},         // R9 soft into raw
    '{6'd8,  32'h10,         6'd4,  32'h10},         // R6 set
    '{6'd8,  32'h20,         6'd4,  32'h30},         // R6 set keeps others
    '{6'd12, 32'h10,         6'd4,  32'h20},         // R6 clear
    '{6'd63, 32'h0,          6'd48, 32'd5},          // R10 lowest enabled
    '{6'd0,  32'h20,         6'd40, 32'h20},         // R7 routed to FIQ
    '{6'd63, 32'h0,          6'd36, 32'h0},          // R7 IRQ status empty
    '{6'd63, 32'h0,          6'd48, 32'hFFFF_FFFF},  // R10 none
    '{6'd5,  32'h8000_0001,  6'd5,  32'h8000_0001},  // R6 direct write
    '{6'd25, 32'h8000_0001,  6'd37, 32'h8000_0001},  // R7 R1 bank 1
    '{6'd63, 32'h0,          6'd48, 32'd32},         // R10 R1 line 32
    '{6'd1,  32'h1,          6'd48, 32'd63},         // R10 line 63
    '{6'd13, 32'h8000_0000,  6'd48, 32'hFFFF_FFFF},  // R10 R6
    '{6'd6,  32'hFFFF,       6'd6,  32'h0},          // R11 bank 2 absent
    '{6'd63, 32'h0,          6'd8,  32'h0},          // R11 write-only
    '{6'd44, 32'h3,          6'd44, 32'h3},          // R8 master
    '{6'd17, 32'hF,          6'd17, 32'hF},          // R4 type reg
    '{6'd21, 32'hA5,         6'd21, 32'hA5},         // R3 polarity reg
    '{6'd45, 32'h3,          6'd45, 32'h0},          // R11 master bank 1
    '{6'd63, 32'h0,          6'd41, 32'h1}           // R7 FIQ bank 1
  };

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [31:0] rv;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_lines = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, rv);
      check($sformatf("vector %0d", i), rv, VEC[i].ex);
    end

    // R2 reset state
    do_reset();
    rd(6'd4, rv);  check("R2 enable", rv, 32'h0);
    rd(6'd0, rv);  check("R2 route", rv, 32'h0);
    rd(6'd48, rv); check("R2 pend", rv, 32'hFFFF_FFFF);
    rd(6'd44, rv); check("R2 master", rv, 32'h0);
    check("R2 outs", {30'd0, irq_out, fiq_out}, 32'h0);

    // R3 level sensing, R8 output gating
    wr(6'd8, 32'h8);
    wr(6'd44, 32'h3);
    irq_lines[3] = 1'b1;
    tick(3);
    rd(6'd32, rv); check("R3 level high", rv, 32'h8);
    check("R8 irq on", {31'd0, irq_out}, 32'h1);
    rd(6'd48, rv); check("R10 level pend", rv, 32'd3);
    wr(6'd44, 32'h2);
    check("R8 irq gated", {31'd0, irq_out}, 32'h0);
    wr(6'd0, 32'h8);
    check("R8 fiq on", {31'd0, fiq_out}, 32'h1);
    wr(6'd44, 32'h1);
    check("R8 fiq gated", {31'd0, fiq_out}, 32'h0);
    wr(6'd0, 32'h0);
    wr(6'd44, 32'h3);
    irq_lines[3] = 1'b0;
    tick(3);
    rd(6'd32, rv); check("R3 level low", rv, 32'h0);
    check("R3 irq off", {31'd0, irq_out}, 32'h0);
    wr(6'd20, 32'h8);
    rd(6'd32, rv); check("R3 active low", rv, 32'h8);
    wr(6'd20, 32'h0);

    // R4 edge on line 40 (bank 1 bit 8)
    wr(6'd17, 32'h100);
    wr(6'd5, 32'h100);
    irq_lines[40] = 1'b1;
    tick(4);
    rd(6'd33, rv); check("R4 rising latched", rv, 32'h100);
    irq_lines[40] = 1'b0;
    tick(4);
    rd(6'd33, rv); check("R4 latch holds", rv, 32'h100);
    wr(6'd29, 32'h100);
    rd(6'd33, rv); check("R5 ack clears", rv, 32'h0);
    wr(6'd21, 32'h100);
    irq_lines[40] = 1'b1;
    tick(4);
    rd(6'd33, rv); check("R4 rise ignored when falling", rv, 32'h0);
    irq_lines[40] = 1'b0;
    tick(4);
    rd(6'd33, rv); check("R4 falling latched", rv, 32'h100);
    wr(6'd21, 32'h0);
    wr(6'd29, 32'h100);
    rd(6'd33, rv); check("R5 ack clears again", rv, 32'h0);

    // R5 new edge collides with acknowledge
    irq_lines[40] = 1'b1;
    tick(4);
    irq_lines[40] = 1'b0;
    tick(4);
    irq_lines[40] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'd29; bus_wdata = 32'h100;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    rd(6'd33, rv); check("R5 edge beats ack", rv, 32'h100);
    rd(6'd48, rv); check("R10 edge pend", rv, 32'd40);
    wr(6'd29, 32'h100);
    rd(6'd33, rv); check("R5 later ack clears", rv, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule